// File: doc/BRIEF.md
# Down-Counting Interval Timer

The block is a register-mapped interval timer built around a 32-bit down counter. Software stores a start value in the load register, which also sets the running counter, and then sets bits in the control register to start the countdown. While running, the counter drops by one on every clock. The clock edge on which it steps from one to zero is the time-out. On that edge a sticky time-out flag is set in the status register. After the time-out the counter either stays at zero or, in periodic mode, takes the stored start value again on the next clock.

The flag stays set until software writes a one to bit 0 of the status register. The interrupt line is the flag gated by an interrupt-enable bit. With a 200 MHz timer clock, a start value of 199,999,999 in periodic mode gives one time-out per second. A start value of 1,999,999 gives one every 10 ms. In general, periodic mode gives one time-out every load+1 clocks.

The bus uses word indices: index 0 is the load register, 1 the counter (read-only), 2 control and 3 status. The control bits are: bit 0 run, bit 1 periodic reload, bit 2 interrupt enable.

Top module: `cntdown_timer`

## Requirements
- R1: After synchronous reset every register reads 0 and `irq` is 0.
- R2: A write to index 0 stores the value as the start value and places it in the counter on the same clock edge. Both read back the written value after that edge.
- R3: With run set (control bit 0) and a nonzero counter, the counter drops by exactly one per clock. With run clear it holds its value.
- R4: On the edge where a running counter steps from 1 to 0, the status bit 0 (time-out flag) becomes 1.
- R5: With periodic reload clear (control bit 1), a running counter that has reached 0 stays at 0 and raises no further time-outs.
- R6: With periodic reload set, a running counter at 0 takes the stored start value on the next clock. Time-outs then repeat every load+1 clocks.
- R7: The time-out flag stays 1 until a write to index 3 with bit 0 equal to 1. A write to index 3 with bit 0 equal to 0 leaves it unchanged.
- R8: When a time-out and a clearing write occur on the same edge, the flag ends at 1.
- R9: `irq` is 1 exactly when the flag is 1 and interrupt enable (control bit 2) is 1.
- R10: Writes to index 1 change nothing.
- R11: A write to index 0 takes priority over counting. If it lands on the edge where the counter would have stepped from 1 to 0, no time-out is raised.
- R12: Only control bits 2:0 are stored. The upper control bits and status bits 31:1 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Word index: 0 load, 1 counter, 2 control, 3 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request: time-out flag AND interrupt enable |

## Verification
A wrong counter value shows up on the counter read-back in the very cycle it occurs. It then moves the time-out edge, so the flag and `irq` go wrong at most load+1 cycles later. A flag that is lost, set twice or cleared by the wrong write shows up at once in status bit 0 and, when interrupts are enabled, on `irq`. A stored start value that is wrong stays hidden until the first periodic reload, which makes the counter read-back differ one cycle after the time-out. For this reason the bench samples every register on every clock rather than only at time-outs.

// File: rtl/cntdown_timer_pkg.sv
package cntdown_timer_pkg;

    typedef enum logic [1:0] {
        SEL_LOAD  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_STAT  = 2'd3
    } reg_sel_e;

    // packed so that run sits at bit 0, reload at bit 1, irq_en at bit 2
    typedef struct packed {
        logic irq_en;
        logic reload;
        logic run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic reg_sel_e decode_sel(input logic [1:0] idx);
        return reg_sel_e'(idx);
    endfunction

endpackage

// File: rtl/cntdown_timer_regs.sv
module cntdown_timer_regs
    import cntdown_timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] cnt,
    input  logic              flag,
    output logic [DATA_W-1:0] load_q,
    output ctrl_t             ctrl_q,
    output logic              load_wr,
    output logic              clr_wr,
    output logic [DATA_W-1:0] bus_rdata
);
    reg_sel_e sel;

    always_comb begin
        sel     = decode_sel(bus_addr[1:0]);
        load_wr = bus_wr && (sel == SEL_LOAD);
        clr_wr  = bus_wr && (sel == SEL_STAT) && bus_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (load_wr)
                load_q <= bus_wdata;
            if (bus_wr && (sel == SEL_CTRL))
                ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_LOAD:  bus_rdata = load_q;
            SEL_COUNT: bus_rdata = cnt;
            SEL_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl_q;
            SEL_STAT:  bus_rdata[0] = flag;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cntdown_timer_core.sv
module cntdown_timer_core #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              reload,
    input  logic              load_wr,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] start_val,
    output logic [DATA_W-1:0] cnt,
    output logic              hit
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    // time-out: the step from one to zero, unless a load write overrides it
    assign hit = run && !load_wr && (cnt == ONE);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load_wr)
            cnt <= load_val;
        else if (run) begin
            if (cnt != '0)
                cnt <= cnt - ONE;
            else if (reload)
                cnt <= start_val;
        end
    end
endmodule

// File: rtl/cntdown_timer_flag.sv
module cntdown_timer_flag (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    // a fresh time-out outranks a clear on the same edge
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (hit)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    assign irq = flag & irq_en;
endmodule

// File: rtl/cntdown_timer.sv
module cntdown_timer
    import cntdown_timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] load_q;
    ctrl_t             ctrl_q;
    logic              load_wr;
    logic              clr_wr;
    logic              hit;
    logic              flag_q;

    cntdown_timer_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt       (cnt_q),
        .flag      (flag_q),
        .load_q    (load_q),
        .ctrl_q    (ctrl_q),
        .load_wr   (load_wr),
        .clr_wr    (clr_wr),
        .bus_rdata (bus_rdata)
    );

    cntdown_timer_core #(.DATA_W(DATA_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .run       (ctrl_q.run),
        .reload    (ctrl_q.reload),
        .load_wr   (load_wr),
        .load_val  (bus_wdata),
        .start_val (load_q),
        .cnt       (cnt_q),
        .hit       (hit)
    );

    cntdown_timer_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .hit    (hit),
        .clr    (clr_wr),
        .irq_en (ctrl_q.irq_en),
        .flag   (flag_q),
        .irq    (irq)
    );
endmodule

// File: rtl/cntdown_timer_chk.sv
module cntdown_timer_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] load_q,
    input logic [2:0]        ctrl,
    input logic              flag,
    input logic              irq
);
    logic ld_w, st_clr, run, rl, ie;
    assign ld_w   = bus_wr && (bus_addr == 2'd0);
    assign st_clr = bus_wr && (bus_addr == 2'd3) && bus_wdata[0];
    assign run    = ctrl[0];
    assign rl     = ctrl[1];
    assign ie     = ctrl[2];

    assert_load_copies_R2: assert property (@(posedge clk) disable iff (rst)
        ld_w |=> (cnt == $past(bus_wdata)) && (load_q == $past(bus_wdata)));

    assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
        (run && !ld_w && cnt != '0) |=> cnt == $past(cnt) - DATA_W'(1));

    assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (rst)
        (!run && !ld_w) |=> $stable(cnt));

    assert_flag_on_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (run && !ld_w && cnt == DATA_W'(1)) |=> flag);

    assert_oneshot_stays_R5: assert property (@(posedge clk) disable iff (rst)
        (run && !rl && !ld_w && cnt == '0) |=> cnt == '0);

    assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
        (run && rl && !ld_w && cnt == '0) |=> cnt == $past(load_q));

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (flag && !st_clr) |=> flag);

    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (rst)
        !flag |-> !irq);

    assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ie);
endmodule

bind cntdown_timer cntdown_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt       (cnt_q),
    .load_q    (load_q),
    .ctrl      (ctrl_q),
    .flag      (flag_q),
    .irq       (irq)
);

// File: tb/cntdown_timer_bench.sv
module cntdown_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq;

    int compared = 0;
    int mismatched = 0;
    string cur_req = "R1";

    // behavioural reference state
    longint m_load = 0, m_cnt = 0;
    int     m_ctrl = 0;
    bit     m_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cntdown_timer u_cntdown_timer (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic cmp(input string req, input longint act, input longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    // read back all four registers and irq through the bus
    task automatic sweep();
        bus_wr = 1'b0;
        for (int i = 0; i < 4; i++) begin
            bus_addr = 2'(i);
            #1;
            case (i)
                0: cmp({cur_req, "/load"},    longint'(bus_rdata), m_load);
                1: cmp({cur_req, "/counter"}, longint'(bus_rdata), m_cnt);
                2: cmp({cur_req, "/control"}, longint'(bus_rdata), longint'(m_ctrl));
                default: cmp({cur_req, "/status"}, longint'(bus_rdata), longint'(m_flag));
            endcase
        end
        cmp({cur_req, "/irq"}, longint'(irq), longint'(m_flag && m_ctrl[2]));
    endtask

    task automatic model(input bit w, input int a, input longint d);
        bit run, rl, timeout;
        run = m_ctrl[0];
        rl  = m_ctrl[1];
        timeout = 0;
        if (w && a == 0) begin
            m_load = d;
            m_cnt  = d;
        end else if (run) begin
            if (m_cnt > 0) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) timeout = 1;
            end else if (rl) begin
                m_cnt = m_load;
            end
        end
        if (w && a == 2) m_ctrl = int'(d) & 7;
        if (w && a == 3 && d[0]) m_flag = 0;
        if (timeout) m_flag = 1;
    endtask

    task automatic step(input bit w, input int a, input longint d);
        sweep();
        bus_wr    = w;
        bus_addr  = 2'(a);
        bus_wdata = DW'(d);
        @(posedge clk);
        model(w, a, d);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur_req = "R1";
        sweep();
        rst = 1'b0;
        idle(1);

        cur_req = "R2";
        step(1, 0, 5);
        cur_req = "R3";
        idle(2);                 // stopped: counter holds
        step(1, 2, 1);           // run, one-shot
        cur_req = "R4";
        idle(6);                 // reaches zero, flag set
        cur_req = "R5";
        idle(4);

        cur_req = "R7";
        step(1, 3, 2);           // bit0 = 0: no clear
        idle(1);
        step(1, 3, 1);           // clear
        idle(1);

        cur_req = "R6";
        step(1, 0, 3);
        step(1, 2, 3);           // run + reload
        idle(12);

        cur_req = "R9";
        step(1, 2, 7);
        idle(6);
        step(1, 2, 3);
        idle(3);

        cur_req = "R8";          // clear every cycle, including time-out edges
        for (int i = 0; i < 10; i++) step(1, 3, 1);
        idle(2);

        cur_req = "R10";
        step(1, 1, 64'hDEAD_BEEF);
        idle(2);

        cur_req = "R11";
        step(1, 2, 1);
        step(1, 3, 1);
        step(1, 0, 2);
        idle(1);                 // counter now 1
        step(1, 0, 9);           // overrides the time-out
        idle(3);

        cur_req = "R12";
        step(1, 2, 64'hFFFF_FFF8);
        step(1, 3, 64'hFFFF_FFFE);
        idle(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule